// File: doc/BRIEF.md
# Programmable Fabric Configuration Sequencer

This block runs the configuration life cycle of a programmable-logic fabric from the host side. A start or hold command from the host pulls the active-low programming request `prog_n_o` low. The sequencer then releases it and waits for the fabric's ready pin (`fab_ok_i`) to come back high. It then paces configuration words from a valid/ready stream onto the fabric data port. It follows the load-done and wake-done pins until the fabric reaches user mode. The current phase is always visible on a 3-bit code.

The block also decodes a 4-bit mode selector. Bit 3 picks a 16-bit or a 32-bit data port. Bits 1:0 pick a clock-to-data ratio. The selector is latched while the programming request is low, and the pacer uses the latched value. If `fab_ok_i` drops during loading or wake-up, the sequencer restarts the full configuration by itself a bounded number of times before declaring a persistent failure. Every command is refused with an error code unless the host holds ownership, power is good and the mode code is known.

States: UNKNOWN, IDLE, PULSE, WAITST, STREAM, SETTLE, USER, FAIL. The transitions are:
- UNKNOWN→IDLE on the first clock after reset.
- Any state except UNKNOWN→PULSE on an accepted command.
- PULSE→WAITST once the minimum low time has passed and hold is released.
- WAITST→STREAM when `fab_ok_i` is high.
- STREAM→SETTLE on a rising `load_done_i`.
- SETTLE→USER on a rising `wake_done_i`.
- STREAM/SETTLE→PULSE on a fabric error while retries remain.
- STREAM/SETTLE→FAIL on a fabric error once the retry budget is spent.

Top module: `cfg_phase_seq`

## Requirements
- R1: While reset is asserted, and in the single cycle right after it is released, `phase_o` reads 5 (unknown). It reads 0 from the next cycle on. `prog_n_o` is 1, `s_ready_o` is 0, `done_o`, `fail_o`, `retries_o` and `err_code_o` are 0.
- R2: `phase_o` encodes idle/power-up as 0, reset (PULSE and WAITST) as 1, loading as 2, wake-up as 3, user mode as 4 and unknown as 5. FAIL reads 0.
- R3: An accepted command holds `prog_n_o` low for exactly PULSE_MIN cycles, or for as long as `hold_rst_i` stays high if that is longer. After release, `phase_o` stays 1 until `fab_ok_i` is high, and is 2 the cycle after.
- R4: Mode decode: `mode_sel_i[3]`=1 selects the 32-bit port, 0 selects the 16-bit port. `mode_sel_i[1:0]` of 0, 1 and 2 give ratio 1, 4 and 8, and 3 is unknown (`mode_ok_o`=0, ratio reported as 1).
- R5: `s_ready_o` is high only in phase 2. After a handshake it stays low for ratio-1 cycles, so handshakes are exactly ratio cycles apart under continuous valid. `cfg_wr_o` pulses the cycle after each handshake with the word on `cfg_data_o`, upper 16 bits forced to 0 on the 16-bit port.
- R6: A rising `load_done_i` in phase 2 gives phase 3 on the next cycle. A rising `wake_done_i` in phase 3 gives phase 4 with `done_o`=1.
- R7: `fab_ok_i` low in phase 2 or 3 with retries left sends the block back to phase 1 next cycle, with `prog_n_o` low and `retries_o` incremented.
- R8: After MAX_RETRY (5) retries, the next fabric error gives `fail_o`=1, phase 0 and `prog_n_o`=1, with `retries_o` held at 5. FAIL is kept until a new command.
- R9: A start or hold command is checked in priority order. Power low gives `err_code_o`=2. Otherwise ownership low gives 1. Otherwise an unknown mode gives 3. A refused command leaves the phase unchanged, and an accepted one sets `err_code_o` to 0.
- R10: `status_o` bits hold live levels: 0 `fab_ok_i`, 1 `load_done_i`, 2 `wake_done_i`, 3 `prog_n_o`, 4 `pwr_good_i`, 5 `own_i`, 6 `done_o`, 7 `fail_o`, 8 `mode_ok_o`, 9 `port32_o`. Bits 11:10 are 0.
- R11: An accepted command clears `retries_o` and leaves FAIL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_i | input | 1 | Host holds ownership of the control block |
| pwr_good_i | input | 1 | Fabric power is good |
| start_i | input | 1 | Start a full configuration |
| hold_rst_i | input | 1 | Hold the fabric in reset while high |
| mode_sel_i | input | 4 | Static mode selector |
| prog_n_o | output | 1 | Active-low programming request to the fabric |
| fab_ok_i | input | 1 | Fabric ready/no-error pin (low = reset or error) |
| load_done_i | input | 1 | Fabric has received all configuration data |
| wake_done_i | input | 1 | Fabric has finished initialization |
| s_data_i | input | DATA_W | Configuration word in |
| s_valid_i | input | 1 | Word valid |
| s_ready_o | output | 1 | Word accepted this cycle when valid |
| cfg_data_o | output | DATA_W | Word presented to the fabric port |
| cfg_wr_o | output | 1 | One-cycle strobe for `cfg_data_o` |
| phase_o | output | 3 | Phase code |
| port32_o | output | 1 | Decoded port width is 32 bits |
| ratio_o | output | RATIO_W | Decoded clock-to-data ratio |
| mode_ok_o | output | 1 | Mode code is known |
| err_code_o | output | 2 | Result of the last command |
| retries_o | output | RETRY_W | Automatic retries in the current run |
| done_o | output | 1 | Fabric is in user mode |
| fail_o | output | 1 | Retry budget spent |
| status_o | output | 12 | Live status vector |

## Verification
Two full runs are driven with different mode codes. The first uses a narrow port at ratio 4 and the second a wide port at ratio 1. This separates the port masking from the pacing gap, and each accepted word is compared through a scoreboard. The second run enters reset through a hold longer than the minimum pulse, which separates hold-driven reset from the timed pulse. It then injects fabric errors in both the loading and wake-up phases until the retry budget is spent. Commands with power, ownership or mode wrong in various combinations check the refusal priority and that the phase is left alone.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int MODE_W = 4;
    localparam int STAT_W = 12;

    typedef enum logic [2:0] {
        PH_POWERUP = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ST_UNKNOWN,
        ST_IDLE,
        ST_PULSE,
        ST_WAITST,
        ST_STREAM,
        ST_SETTLE,
        ST_USER,
        ST_FAIL
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_OWNER = 2'd1,
        ERR_POWER = 2'd2,
        ERR_MODE  = 2'd3
    } err_e;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_seq_pkg::*;
#(
    parameter int RATIO_W = 4
) (
    input  logic [MODE_W-1:0]  mode_i,
    output logic               wide_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               known_o
);

    always_comb begin
        wide_o  = mode_i[3];
        known_o = 1'b1;
        ratio_o = RATIO_W'(1);
        unique case (mode_i[1:0])
            2'd0: ratio_o = RATIO_W'(1);
            2'd1: ratio_o = RATIO_W'(4);
            2'd2: ratio_o = RATIO_W'(8);
            2'd3: known_o = 1'b0;
        endcase
    end

    // bit 2 selects power-on delay on the fabric side and has no effect here
    logic unused_bit;
    assign unused_bit = mode_i[2];

endmodule

// File: rtl/cfg_low_timer.sv
module cfg_low_timer #(
    parameter int PULSE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expired_o
);

    localparam int CW = $clog2(PULSE_MIN + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = (cnt_q == CW'(PULSE_MIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en_i)      cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cfg_word_pacer.sv
module cfg_word_pacer #(
    parameter int DATA_W  = 32,
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               wide_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [DATA_W-1:0]  s_data_i,
    input  logic               s_valid_i,
    output logic               s_ready_o,
    output logic               wr_o,
    output logic [DATA_W-1:0]  data_o
);

    localparam int HALF = DATA_W / 2;

    logic [RATIO_W-1:0] hold_q;
    logic [DATA_W-1:0]  narrow;
    logic               take;

    assign narrow    = {{(DATA_W-HALF){1'b0}}, s_data_i[HALF-1:0]};
    assign s_ready_o = en_i && (hold_q == '0);
    assign take      = s_valid_i && s_ready_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            wr_o   <= 1'b0;
            data_o <= '0;
        end else begin
            wr_o <= take;
            if (take) begin
                data_o <= wide_i ? s_data_i : narrow;
                hold_q <= ratio_i - 1'b1;
            end else if (!en_i) begin
                hold_q <= '0;
            end else if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq
    import cfg_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RATIO_W   = 4,
    parameter int PULSE_MIN = 4,
    parameter int MAX_RETRY = 5,
    localparam int RETRY_W  = $clog2(MAX_RETRY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               own_i,
    input  logic               pwr_good_i,
    input  logic               start_i,
    input  logic               hold_rst_i,
    input  logic [3:0]         mode_sel_i,
    output logic               prog_n_o,
    input  logic               fab_ok_i,
    input  logic               load_done_i,
    input  logic               wake_done_i,
    input  logic [DATA_W-1:0]  s_data_i,
    input  logic               s_valid_i,
    output logic               s_ready_o,
    output logic [DATA_W-1:0]  cfg_data_o,
    output logic               cfg_wr_o,
    output logic [2:0]         phase_o,
    output logic               port32_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               mode_ok_o,
    output logic [1:0]         err_code_o,
    output logic [RETRY_W-1:0] retries_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [11:0]        status_o
);

    state_e             state_q, state_d;
    err_e               cmd_err, err_q;
    logic [RETRY_W-1:0] retry_q;
    logic [MODE_W-1:0]  mode_q;
    logic               load_q, wake_q;
    logic               cmd_live, cmd_ok, fab_err, retry_left;
    logic               tmr_done;
    logic               pace_wide, pace_known;
    logic [RATIO_W-1:0] pace_ratio;

    // live decode gates commands and feeds status; latched decode feeds the pacer
    cfg_mode_decode #(.RATIO_W(RATIO_W)) u_dec_live (
        .mode_i (mode_sel_i),
        .wide_o (port32_o),
        .ratio_o(ratio_o),
        .known_o(mode_ok_o)
    );

    cfg_mode_decode #(.RATIO_W(RATIO_W)) u_dec_held (
        .mode_i (mode_q),
        .wide_o (pace_wide),
        .ratio_o(pace_ratio),
        .known_o(pace_known)
    );

    cfg_low_timer #(.PULSE_MIN(PULSE_MIN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state_q == ST_PULSE),
        .expired_o(tmr_done)
    );

    cfg_word_pacer #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     ((state_q == ST_STREAM) && pace_known),
        .wide_i   (pace_wide),
        .ratio_i  (pace_ratio),
        .s_data_i (s_data_i),
        .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o),
        .wr_o     (cfg_wr_o),
        .data_o   (cfg_data_o)
    );

    // command gate: power first, then ownership, then mode
    always_comb begin
        if (!pwr_good_i)     cmd_err = ERR_POWER;
        else if (!own_i)     cmd_err = ERR_OWNER;
        else if (!mode_ok_o) cmd_err = ERR_MODE;
        else                 cmd_err = ERR_NONE;
    end

    assign cmd_live   = (start_i || hold_rst_i) && (state_q != ST_UNKNOWN);
    assign cmd_ok     = cmd_live && (cmd_err == ERR_NONE);
    assign fab_err    = ((state_q == ST_STREAM) || (state_q == ST_SETTLE)) && !fab_ok_i;
    assign retry_left = (retry_q < RETRY_W'(MAX_RETRY));

    // state register and bookkeeping of the run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNKNOWN;
            err_q   <= ERR_NONE;
            retry_q <= '0;
            mode_q  <= '0;
            load_q  <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            load_q  <= load_done_i;
            wake_q  <= wake_done_i;
            if (cmd_live) err_q <= cmd_err;
            if (cmd_ok)                      retry_q <= '0;
            else if (fab_err && retry_left)  retry_q <= retry_q + 1'b1;
            if (state_q == ST_PULSE) mode_q <= mode_sel_i;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_ok) begin
            state_d = ST_PULSE;
        end else begin
            unique case (state_q)
                ST_UNKNOWN: state_d = ST_IDLE;
                ST_IDLE:    state_d = ST_IDLE;
                ST_PULSE:   if (tmr_done && !hold_rst_i) state_d = ST_WAITST;
                ST_WAITST:  if (fab_ok_i) state_d = ST_STREAM;
                ST_STREAM: begin
                    if (!fab_ok_i)                    state_d = retry_left ? ST_PULSE : ST_FAIL;
                    else if (load_done_i && !load_q)  state_d = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (!fab_ok_i)                    state_d = retry_left ? ST_PULSE : ST_FAIL;
                    else if (wake_done_i && !wake_q)  state_d = ST_USER;
                end
                ST_USER:    state_d = ST_USER;
                ST_FAIL:    state_d = ST_FAIL;
            endcase
        end
    end

    // outputs
    phase_e phase;
    always_comb begin
        unique case (state_q)
            ST_UNKNOWN:          phase = PH_UNKNOWN;
            ST_IDLE, ST_FAIL:    phase = PH_POWERUP;
            ST_PULSE, ST_WAITST: phase = PH_RESET;
            ST_STREAM:           phase = PH_CONFIG;
            ST_SETTLE:           phase = PH_INIT;
            ST_USER:             phase = PH_USER;
        endcase
        phase_o    = phase;
        prog_n_o   = (state_q != ST_PULSE);
        done_o     = (state_q == ST_USER);
        fail_o     = (state_q == ST_FAIL);
        err_code_o = err_q;
        retries_o  = retry_q;
        status_o   = {2'b00, port32_o, mode_ok_o, fail_o, done_o,
                      own_i, pwr_good_i, prog_n_o, wake_done_i, load_done_i, fab_ok_i};
    end

endmodule

// File: rtl/cfg_phase_seq_chk.sv
module cfg_phase_seq_chk #(
    parameter int RATIO_W   = 4,
    parameter int MAX_RETRY = 5,
    parameter int RETRY_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               hold_rst_i,
    input logic               pwr_good_i,
    input logic               fab_ok_i,
    input logic               s_valid_i,
    input logic               s_ready_o,
    input logic               cfg_wr_o,
    input logic               prog_n_o,
    input logic [2:0]         phase_o,
    input logic [RETRY_W-1:0] retries_o,
    input logic [1:0]         err_code_o,
    input logic               fail_o,
    input logic [RATIO_W-1:0] pace_ratio
);

    // R1
    unknown_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd5) |=> (phase_o == 3'd0));

    // R5
    ready_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (phase_o == 3'd2));

    // R5
    pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && s_ready_o && (pace_ratio != RATIO_W'(1))) |=> !s_ready_o);

    // R5
    wr_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> $past(s_valid_i && s_ready_o));

    // R3
    hold_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n_o && hold_rst_i) |=> !prog_n_o);

    // R7
    error_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase_o == 3'd2) || (phase_o == 3'd3)) && !fab_ok_i) |=> (!prog_n_o || fail_o));

    // R8
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retries_o <= RETRY_W'(MAX_RETRY));

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i && !hold_rst_i) |=> fail_o);

    // R9
    refuse_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_i || hold_rst_i) && !pwr_good_i && (phase_o != 3'd5)) |=> (err_code_o == 2'd2));

endmodule

bind cfg_phase_seq cfg_phase_seq_chk #(
    .RATIO_W  (RATIO_W),
    .MAX_RETRY(MAX_RETRY),
    .RETRY_W  (RETRY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .hold_rst_i(hold_rst_i),
    .pwr_good_i(pwr_good_i),
    .fab_ok_i  (fab_ok_i),
    .s_valid_i (s_valid_i),
    .s_ready_o (s_ready_o),
    .cfg_wr_o  (cfg_wr_o),
    .prog_n_o  (prog_n_o),
    .phase_o   (phase_o),
    .retries_o (retries_o),
    .err_code_o(err_code_o),
    .fail_o    (fail_o),
    .pace_ratio(pace_ratio)
);

// File: tb/cfg_phase_seq_bench.sv
`timescale 1ns/1ps
module cfg_phase_seq_bench;

    localparam int DATA_W    = 32;
    localparam int RATIO_W   = 4;
    localparam int PULSE_MIN = 4;
    localparam int MAX_RETRY = 5;
    localparam int WD_LIMIT  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              own_i = 1'b0, pwr_good_i = 1'b0, start_i = 1'b0, hold_rst_i = 1'b0;
    logic [3:0]        mode_sel_i = 4'd0;
    logic              prog_n_o;
    logic              fab_ok_i = 1'b0, load_done_i = 1'b0, wake_done_i = 1'b0;
    logic [DATA_W-1:0] s_data_i = '0;
    logic              s_valid_i = 1'b0;
    logic              s_ready_o;
    logic [DATA_W-1:0] cfg_data_o;
    logic              cfg_wr_o;
    logic [2:0]        phase_o;
    logic              port32_o;
    logic [RATIO_W-1:0] ratio_o;
    logic              mode_ok_o;
    logic [1:0]        err_code_o;
    logic [2:0]        retries_o;
    logic              done_o, fail_o;
    logic [11:0]       status_o;

    cfg_phase_seq #(.DATA_W(DATA_W), .RATIO_W(RATIO_W), .PULSE_MIN(PULSE_MIN),
                    .MAX_RETRY(MAX_RETRY)) u_cfg_phase_seq (
        .clk(clk), .rst_n(rst_n), .own_i(own_i), .pwr_good_i(pwr_good_i),
        .start_i(start_i), .hold_rst_i(hold_rst_i), .mode_sel_i(mode_sel_i),
        .prog_n_o(prog_n_o), .fab_ok_i(fab_ok_i), .load_done_i(load_done_i),
        .wake_done_i(wake_done_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o), .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o),
        .phase_o(phase_o), .port32_o(port32_o), .ratio_o(ratio_o),
        .mode_ok_o(mode_ok_o), .err_code_o(err_code_o), .retries_o(retries_o),
        .done_o(done_o), .fail_o(fail_o), .status_o(status_o)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [DATA_W-1:0] exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    // driver: offers one word, records the handshake cycle and the expected port word
    task automatic send_word(input logic [31:0] d, input logic wide, output int hs_cyc);
        s_valid_i = 1'b1;
        s_data_i  = d;
        for (int g = 0; g < 64; g++) begin
            if (s_ready_o) break;
            tick();
        end
        exp_q.push_back(wide ? d : {16'h0000, d[15:0]});
        hs_cyc = cyc;
        tick();
        s_valid_i = 1'b0;
    endtask

    // monitor: pops one expected word per strobe
    always @(negedge clk) begin
        if (rst_n && cfg_wr_o) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R5 unexpected strobe: got %h expected none", cfg_data_o);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                check("R5 port word", cfg_data_o, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, c, lowc;
        logic [3:0] r;

        repeat (3) tick();
        check("R1 phase in reset", phase_o, 32'd5);
        rst_n = 1'b1;
        check("R1 phase unknown", phase_o, 32'd5);
        check("R1 prog_n", prog_n_o, 32'd1);
        check("R1 ready", s_ready_o, 32'd0);
        check("R1 flags", {done_o, fail_o, retries_o, err_code_o}, 32'd0);
        tick();
        check("R1 phase powerup", phase_o, 32'd0);

        // R10 status vector in idle
        own_i = 1'b1; pwr_good_i = 1'b1; fab_ok_i = 1'b1;
        tick();
        check("R10 idle status", status_o, 32'h139);

        // R4 decode over all codes
        for (int m = 0; m < 16; m++) begin
            mode_sel_i = 4'(m);
            tick();
            r = (m[1:0] == 2'd1) ? 4'd4 : (m[1:0] == 2'd2) ? 4'd8 : 4'd1;
            check("R4 port32", port32_o, 32'(m[3]));
            check("R4 ratio", ratio_o, 32'(r));
            check("R4 known", mode_ok_o, (m[1:0] != 2'd3) ? 32'd1 : 32'd0);
        end

        // R9 refusals in idle
        mode_sel_i = 4'd0;
        pwr_good_i = 1'b0; own_i = 1'b1;
        pulse_start();
        check("R9 power refused", err_code_o, 32'd2);
        check("R9 phase kept", phase_o, 32'd0);
        pwr_good_i = 1'b1; own_i = 1'b0;
        pulse_start();
        check("R9 owner refused", err_code_o, 32'd1);
        pwr_good_i = 1'b0;
        pulse_start();
        check("R9 power before owner", err_code_o, 32'd2);
        pwr_good_i = 1'b1; own_i = 1'b1; mode_sel_i = 4'd3;
        pulse_start();
        check("R9 mode refused", err_code_o, 32'd3);
        check("R9 prog_n kept", prog_n_o, 32'd1);
        own_i = 1'b0; mode_sel_i = 4'd0; hold_rst_i = 1'b1;
        tick();
        hold_rst_i = 1'b0;
        check("R9 hold refused", err_code_o, 32'd1);
        check("R9 hold no reset", prog_n_o, 32'd1);
        own_i = 1'b1;

        // run 1: 16-bit port, ratio 4
        mode_sel_i = 4'd1;
        pulse_start();
        check("R3 accepted", err_code_o, 32'd0);
        check("R2 reset phase", phase_o, 32'd1);
        fab_ok_i = 1'b0; load_done_i = 1'b0; wake_done_i = 1'b0;
        lowc = 0;
        for (int g = 0; g < 64 && !prog_n_o; g++) begin
            lowc++;
            tick();
        end
        check("R3 pulse length", lowc, PULSE_MIN);
        check("R3 waits for fabric", phase_o, 32'd1);
        tick();
        check("R3 still waiting", phase_o, 32'd1);
        fab_ok_i = 1'b1;
        tick();
        check("R3 config phase", phase_o, 32'd2);
        check("R5 ready in config", s_ready_o, 32'd1);
        send_word(32'hDEADBEEF, 1'b0, a);
        send_word(32'h12345678, 1'b0, b);
        send_word(32'hA5A50F0F, 1'b0, c);
        check("R5 gap ratio 4 first", b - a, 32'd4);
        check("R5 gap ratio 4 second", c - b, 32'd4);
        load_done_i = 1'b1;
        tick();
        check("R6 init phase", phase_o, 32'd3);
        check("R5 no ready in init", s_ready_o, 32'd0);
        wake_done_i = 1'b1;
        tick();
        check("R6 user phase", phase_o, 32'd4);
        check("R6 done", done_o, 32'd1);
        check("R10 user status", status_o, 32'h17F);
        own_i = 1'b0;
        pulse_start();
        check("R9 refused in user", err_code_o, 32'd1);
        check("R9 user kept", phase_o, 32'd4);
        own_i = 1'b1;

        // run 2: 32-bit port, ratio 1, entered by a long hold
        mode_sel_i = 4'd8;
        hold_rst_i = 1'b1;
        tick();
        fab_ok_i = 1'b0; load_done_i = 1'b0; wake_done_i = 1'b0;
        lowc = 0;
        for (int g = 0; g < 10; g++) begin
            if (!prog_n_o) lowc++;
            tick();
        end
        check("R3 hold keeps reset", lowc, 32'd10);
        hold_rst_i = 1'b0;
        tick();
        check("R3 released after hold", prog_n_o, 32'd1);
        check("R2 waiting phase", phase_o, 32'd1);
        fab_ok_i = 1'b1;
        tick();
        check("R2 config phase", phase_o, 32'd2);
        send_word(32'hCAFEF00D, 1'b1, a);
        send_word(32'h0BADC0DE, 1'b1, b);
        send_word(32'h80000001, 1'b1, c);
        check("R5 gap ratio 1 first", b - a, 32'd1);
        check("R5 gap ratio 1 second", c - b, 32'd1);

        // R7 retries, one of them raised in the wake-up phase
        for (int k = 1; k <= MAX_RETRY; k++) begin
            if (k == 2) begin
                load_done_i = 1'b1;
                tick();
                check("R6 init before error", phase_o, 32'd3);
            end
            fab_ok_i = 1'b0;
            tick();
            check("R7 back to reset", phase_o, 32'd1);
            check("R7 prog_n low", prog_n_o, 32'd0);
            check("R7 retry count", retries_o, 32'(k));
            load_done_i = 1'b0;
            for (int g = 0; g < 64 && !prog_n_o; g++) tick();
            fab_ok_i = 1'b1;
            tick();
            check("R7 reloading", phase_o, 32'd2);
        end
        fab_ok_i = 1'b0;
        tick();
        check("R8 fail flag", fail_o, 32'd1);
        check("R8 fail phase", phase_o, 32'd0);
        check("R8 prog_n high", prog_n_o, 32'd1);
        check("R8 retries held", retries_o, 32'd5);
        tick();
        check("R8 fail kept", fail_o, 32'd1);

        // R11 new command clears the run
        pulse_start();
        check("R11 leaves fail", fail_o, 32'd0);
        check("R11 retries cleared", retries_o, 32'd0);
        check("R11 reset phase", phase_o, 32'd1);
        tick();

        check("R5 scoreboard drained", exp_q.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule